// File: doc/BRIEF.md
# Multi-Channel Compare Timer

This block is a memory-mapped timer. A 32-bit time base counts up by one on every clock, and software can read it or load it with a new value. Five compare channels each watch the top five bits of the time base. Each channel holds a 5-bit compare field and a 5-bit don't-care mask.

When a channel's masked compare starts to hold, the channel latches an interrupt status bit. If its output is enabled, it also drives its pin to a programmed level. While the compare does not hold, the pin shows the inverse of that level. Software can also set and clear status bits directly, through two separate write-only registers. Each status bit is gated by an interrupt-mask bit onto one of five interrupt lines.

The register port is a simple single-cycle bus. Writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from the current register state while `bus_sel` is high. Only whole-word accesses are decoded: an address with either low bit set selects nothing.

Top module: `cmp_timer`

## Requirements
- R1: The time base at offset 0x00 increments by one on every clock. A write there loads the written value, which reads back at once, and counting resumes from it. Reset sets the time base to 0.
- R2: Channel n matches when bits 31:27 of the time base equal its compare field, ignoring every bit position whose mask bit is 1. The compare field of channel n is at offset 0x80+4n and its mask at 0xC0+4n, both held in bits 31:27.
- R3: A channel's status bit is set on the clock after a change from no match to match. A match that is already present when reset is released, or that simply continues, sets nothing.
- R4: The output-enable register (0x10) and the output-level register (0x14) hold channel n in bit 31-n. An enabled pin equals its level bit while its channel matches and the inverse otherwise. A disabled pin is 0. A pin changes on the same clock as the status bit.
- R5: Status reads at 0x1C with channel n in bit 15-n. Writing 0x20 sets every status bit written as 1. Writing 0x24 clears every status bit written as 1. A match rise in the same cycle as a clear wins. Both command offsets read as 0.
- R6: The interrupt mask at 0x18 holds channel n in bit 15-n. Interrupt line n is high exactly when status bit n and mask bit n are both 1, starting with the clock that changes either of them.
- R7: The interrupt-enable register at 0x28 stores bits 15:11 for readback only and does not affect the interrupt lines.
- R8: Reset clears enable, level, mask, enable and status bits, every compare field and every mask field, and drives all pins and interrupt lines low.
- R9: Offsets outside the map, and any address with a nonzero low two bits, read as 0 and ignore writes.
- R10: Register writes keep only their defined bits (31:27 for enable, level, compare and mask fields; 15:11 for interrupt registers). All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| tmr_pin | output | 5 | Channel output pins, bit n = channel n |
| tmr_irq | output | 5 | Interrupt lines, bit n = channel n |

## Verification
- **Register reads and interrupt lines:** a read returns its value in the same cycle it is presented. A write or status command shows on the interrupt lines right after its own edge.
- **Compare events:** these take one more edge. The edge after a load puts a matching value in the time base, and status and pin change on the following edge.
- **How the bench samples:** the bench counts edges from each time-base load and samples on the falling edge. It checks status and pin both one edge before and on the edge the event is due.
- **Clear against a match rise:** a clear write is placed on the very edge where a match rise is registered, to show which one wins.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    parameter int NUM_CH  = 5;
    parameter int TB_W    = 32;
    parameter int FLD_W   = 5;
    parameter int ADDR_W  = 8;
    parameter int IRQ_MSB = 15;

    localparam int FLD_LSB = TB_W - FLD_W;
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    localparam logic [ADDR_W-1:0] OFS_TB    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OE    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OL    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 8'hC0;

    typedef logic [NUM_CH-1:0] ch_vec_t;
    typedef logic [FLD_W-1:0]  fld_t;

    typedef struct packed {
        ch_vec_t                      oe;
        ch_vec_t                      ol;
        ch_vec_t                      imask;
        ch_vec_t                      ien;
        logic [NUM_CH-1:0][FLD_W-1:0] cmp;
        logic [NUM_CH-1:0][FLD_W-1:0] msk;
    } cfg_t;

    typedef enum logic [3:0] {
        R_NONE, R_TB, R_OE, R_OL, R_IMASK, R_STAT,
        R_SET, R_CLR, R_IEN, R_CMP, R_MSK
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel = R_NONE;
        d.idx = '0;
        if (a[1:0] == 2'b00) begin
            case (a)
                OFS_TB:    d.sel = R_TB;
                OFS_OE:    d.sel = R_OE;
                OFS_OL:    d.sel = R_OL;
                OFS_IMASK: d.sel = R_IMASK;
                OFS_STAT:  d.sel = R_STAT;
                OFS_SET:   d.sel = R_SET;
                OFS_CLR:   d.sel = R_CLR;
                OFS_IEN:   d.sel = R_IEN;
                default:   ;
            endcase
            for (int n = 0; n < NUM_CH; n++) begin
                if (a == OFS_CMP + ADDR_W'(4 * n)) begin
                    d.sel = R_CMP;
                    d.idx = IDX_W'(n);
                end
                if (a == OFS_MSK + ADDR_W'(4 * n)) begin
                    d.sel = R_MSK;
                    d.idx = IDX_W'(n);
                end
            end
        end
        return d;
    endfunction

    // channel n lives at bit TB_W-1-n of a word
    function automatic logic [TB_W-1:0] place_hi(input ch_vec_t v);
        logic [TB_W-1:0] r;
        r = '0;
        for (int n = 0; n < NUM_CH; n++) r[TB_W-1-n] = v[n];
        return r;
    endfunction

    function automatic ch_vec_t take_hi(input logic [TB_W-1:0] w);
        ch_vec_t v;
        for (int n = 0; n < NUM_CH; n++) v[n] = w[TB_W-1-n];
        return v;
    endfunction

    // channel n lives at bit IRQ_MSB-n of a word
    function automatic logic [TB_W-1:0] place_irq(input ch_vec_t v);
        logic [TB_W-1:0] r;
        r = '0;
        for (int n = 0; n < NUM_CH; n++) r[IRQ_MSB-n] = v[n];
        return r;
    endfunction

    function automatic ch_vec_t take_irq(input logic [TB_W-1:0] w);
        ch_vec_t v;
        for (int n = 0; n < NUM_CH; n++) v[n] = w[IRQ_MSB-n];
        return v;
    endfunction

    function automatic logic fld_hit(input fld_t tbf, input fld_t c, input fld_t m);
        return ((tbf ^ c) & ~m) == '0;
    endfunction

endpackage

// File: rtl/cmp_timer_tb.sv
module cmp_timer_tb
    import cmp_timer_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [TB_W-1:0] load_val,
    output logic [TB_W-1:0] tb_q
);

    always_ff @(posedge clk) begin
        if (rst)       tb_q <= '0;
        else if (load) tb_q <= load_val;
        else           tb_q <= tb_q + TB_W'(1);
    end

    // R1: without a load the count advances by exactly one
    a_r1_tb_step: assert property (@(posedge clk) disable iff (rst)
        !load |=> tb_q == $past(tb_q) + TB_W'(1));

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan
    import cmp_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  fld_t tb_fld,
    input  fld_t cmp,
    input  fld_t msk,
    input  logic oe,
    input  logic ol,
    output logic rise,
    output logic pin
);

    logic hit, hit_q;

    assign hit  = fld_hit(tb_fld, cmp, msk);
    assign rise = hit & ~hit_q;

    // hit_q starts high so a match present at reset release is not an event
    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q <= 1'b1;
            pin   <= 1'b0;
        end else begin
            hit_q <= hit;
            pin   <= oe & (hit ? ol : ~ol);
        end
    end

    // R4: a disabled output is low on the next clock
    a_r4_pin_off: assert property (@(posedge clk) disable iff (rst)
        !oe |=> !pin);

    // R3: an event lasts a single cycle
    a_r3_rise_once: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TB_W-1:0]   bus_wdata,
    output logic [TB_W-1:0]   bus_rdata,
    input  logic [TB_W-1:0]   tb_q,
    input  ch_vec_t           hw_rise,
    output logic              tb_load,
    output cfg_t              cfg_q,
    output ch_vec_t           status_q
);

    dec_t    dec;
    logic    wr_en;
    ch_vec_t set_bits, clr_bits;

    assign dec      = decode(bus_addr);
    assign wr_en    = bus_sel & bus_wr;
    assign tb_load  = wr_en && dec.sel == R_TB;
    assign set_bits = (wr_en && dec.sel == R_SET) ? take_irq(bus_wdata) : '0;
    assign clr_bits = (wr_en && dec.sel == R_CLR) ? take_irq(bus_wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            status_q <= '0;
        end else begin
            // a hardware event is applied after the clear, so it is never lost
            status_q <= (status_q & ~clr_bits) | set_bits | hw_rise;
            if (wr_en) begin
                case (dec.sel)
                    R_OE:    cfg_q.oe    <= take_hi(bus_wdata);
                    R_OL:    cfg_q.ol    <= take_hi(bus_wdata);
                    R_IMASK: cfg_q.imask <= take_irq(bus_wdata);
                    R_IEN:   cfg_q.ien   <= take_irq(bus_wdata);
                    R_CMP: begin
                        for (int n = 0; n < NUM_CH; n++)
                            if (dec.idx == IDX_W'(n)) cfg_q.cmp[n] <= bus_wdata[TB_W-1:FLD_LSB];
                    end
                    R_MSK: begin
                        for (int n = 0; n < NUM_CH; n++)
                            if (dec.idx == IDX_W'(n)) cfg_q.msk[n] <= bus_wdata[TB_W-1:FLD_LSB];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (dec.sel)
                R_TB:    bus_rdata = tb_q;
                R_OE:    bus_rdata = place_hi(cfg_q.oe);
                R_OL:    bus_rdata = place_hi(cfg_q.ol);
                R_IMASK: bus_rdata = place_irq(cfg_q.imask);
                R_STAT:  bus_rdata = place_irq(status_q);
                R_IEN:   bus_rdata = place_irq(cfg_q.ien);
                R_CMP: begin
                    for (int n = 0; n < NUM_CH; n++)
                        if (dec.idx == IDX_W'(n)) bus_rdata = {cfg_q.cmp[n], {FLD_LSB{1'b0}}};
                end
                R_MSK: begin
                    for (int n = 0; n < NUM_CH; n++)
                        if (dec.idx == IDX_W'(n)) bus_rdata = {cfg_q.msk[n], {FLD_LSB{1'b0}}};
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R9: a misaligned write leaves every configuration register unchanged
    a_r9_misaligned_wr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr[1:0] != 2'b00) |=> cfg_q == $past(cfg_q));

    // R10: field registers never return bits below the field
    a_r10_rd_unused: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && dec.sel inside {R_OE, R_OL, R_CMP, R_MSK})
            |-> bus_rdata[FLD_LSB-1:0] == '0);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_src
        // R5: a status bit only rises from a set command or a match event
        a_r5_status_source: assert property (@(posedge clk) disable iff (rst)
            $rose(status_q[n]) |-> $past(hw_rise[n] || set_bits[n]));
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TB_W-1:0]   bus_wdata,
    output logic [TB_W-1:0]   bus_rdata,
    output logic [NUM_CH-1:0] tmr_pin,
    output logic [NUM_CH-1:0] tmr_irq
);

    logic [TB_W-1:0] tb_q;
    logic            tb_load;
    cfg_t            cfg_q;
    ch_vec_t         status_q, hw_rise;

    cmp_timer_tb u_tb (
        .clk      (clk),
        .rst      (rst),
        .load     (tb_load),
        .load_val (bus_wdata),
        .tb_q     (tb_q)
    );

    cmp_timer_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tb_q      (tb_q),
        .hw_rise   (hw_rise),
        .tb_load   (tb_load),
        .cfg_q     (cfg_q),
        .status_q  (status_q)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        cmp_timer_chan u_ch (
            .clk    (clk),
            .rst    (rst),
            .tb_fld (tb_q[TB_W-1:FLD_LSB]),
            .cmp    (cfg_q.cmp[n]),
            .msk    (cfg_q.msk[n]),
            .oe     (cfg_q.oe[n]),
            .ol     (cfg_q.ol[n]),
            .rise   (hw_rise[n]),
            .pin    (tmr_pin[n])
        );
    end

    assign tmr_irq = status_q & cfg_q.imask;

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tmr_pin;
    logic [4:0]  tmr_irq;

    int n_run = 0;
    int n_fail = 0;

    cmp_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_pin   (tmr_pin),
        .tmr_irq   (tmr_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] hi_w(input logic [4:0] v);
        logic [31:0] r = '0;
        for (int i = 0; i < 5; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] irq_w(input logic [4:0] v);
        logic [31:0] r = '0;
        for (int i = 0; i < 5; i++) r[15-i] = v[i];
        return r;
    endfunction

    function automatic logic [4:0] irq_v(input logic [31:0] w);
        logic [4:0] v;
        for (int i = 0; i < 5; i++) v[i] = w[15-i];
        return v;
    endfunction

    function automatic logic exp_hit(input logic [4:0] t, input logic [4:0] c, input logic [4:0] m);
        for (int i = 0; i < 5; i++)
            if (!m[i] && t[i] != c[i]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [4:0]  st, imask;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1);

        // R8: reset state
        rd(8'h00, d); chk("R8 tb after reset", d, 32'd1);
        rd(8'h10, d); chk("R8 oe", d, 0);
        rd(8'h14, d); chk("R8 ol", d, 0);
        rd(8'h18, d); chk("R8 imask", d, 0);
        rd(8'h1C, d); chk("R8 status", d, 0);
        rd(8'h28, d); chk("R8 ien", d, 0);
        rd(8'h88, d); chk("R8 cmp2", d, 0);
        rd(8'hD0, d); chk("R8 msk4", d, 0);
        chk("R8 pins", {27'd0, tmr_pin}, 0);
        chk("R8 irq", {27'd0, tmr_irq}, 0);

        // R1: load and count
        wr(8'h00, 32'h1234_5670);
        rd(8'h00, d); chk("R1 loaded", d, 32'h1234_5670);
        step(3);
        rd(8'h00, d); chk("R1 counted", d, 32'h1234_5673);

        // R10: only defined bits retained
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R10 oe bits", d, 32'hF800_0000);
        wr(8'h88, 32'hFFFF_FFFF);
        rd(8'h88, d); chk("R10 cmp bits", d, 32'hF800_0000);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R10 imask bits", d, 32'h0000_F800);
        wr(8'h18, 32'h0);
        wr(8'h10, 32'h0);

        // R9: unmapped and misaligned accesses
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R9 unmapped read", d, 0);
        wr(8'h11, 32'hFFFF_FFFF);
        rd(8'h10, d); chk("R9 misaligned write ignored", d, 0);
        rd(8'h12, d); chk("R9 misaligned read", d, 0);
        rd(8'hD4, d); chk("R9 past last mask", d, 0);

        // R7: enable register has no effect on lines
        wr(8'h1C, 32'h0);
        wr(8'h20, irq_w(5'b00100));
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h28, d); chk("R7 ien readback", d, 32'h0000_F800);
        chk("R7 irq stays low", {27'd0, tmr_irq}, 0);
        wr(8'h24, 32'hFFFF_FFFF);

        // R3/R4: timed compare event on random channels
        for (int it = 0; it < 6; it++) begin
            int unsigned ch;
            logic [4:0] c;
            logic ol;
            ch = $urandom_range(4, 0);
            c  = 5'($urandom);
            ol = 1'($urandom);
            wr(8'h80 + 8'(4 * ch), {c, 27'd0});
            wr(8'hC0 + 8'(4 * ch), 32'h0);
            wr(8'h10, hi_w(5'(1 << ch)));
            wr(8'h14, ol ? hi_w(5'(1 << ch)) : 32'h0);
            wr(8'h24, 32'hFFFF_FFFF);
            wr(8'h00, {c, 27'd0} - 32'd4);
            step(4);
            rd(8'h1C, d); chk("R3 no status before match", {31'd0, d[15-ch]}, 0);
            chk("R4 pin inverse before match", {31'd0, tmr_pin[ch]}, {31'd0, ~ol});
            step(1);
            rd(8'h1C, d); chk("R3 status on match", {31'd0, d[15-ch]}, 1);
            chk("R4 pin level on match", {31'd0, tmr_pin[ch]}, {31'd0, ol});
            wr(8'h24, 32'hFFFF_FFFF);
            step(3);
            rd(8'h1C, d); chk("R3 continuing match no reset", {31'd0, d[15-ch]}, 0);
        end

        // R2/R4: masked compare against random patterns
        for (int it = 0; it < 12; it++) begin
            int unsigned ch;
            logic [4:0] c, m, t;
            logic ol, h;
            ch = $urandom_range(4, 0);
            c  = 5'($urandom);
            m  = 5'($urandom) & 5'h0F;
            t  = (it % 3 == 0) ? (c ^ (5'($urandom) & m)) : 5'($urandom);
            ol = 1'($urandom);
            h  = exp_hit(t, c, m);
            wr(8'h80 + 8'(4 * ch), {c, 27'd0});
            wr(8'hC0 + 8'(4 * ch), {m, 27'd0});
            wr(8'h10, hi_w(5'(1 << ch)));
            wr(8'h14, ol ? hi_w(5'(1 << ch)) : 32'h0);
            wr(8'h00, {~c, 27'd0});
            wr(8'h24, 32'hFFFF_FFFF);
            wr(8'h00, {t, 27'd0});
            step(1);
            rd(8'h1C, d); chk("R2 masked match status", {31'd0, d[15-ch]}, {31'd0, h});
            chk("R4 pin follows match", {31'd0, tmr_pin[ch]}, {31'd0, h ? ol : ~ol});
        end

        // R4: disabled pin is low
        wr(8'h10, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        step(1);
        chk("R4 disabled pins", {27'd0, tmr_pin}, 0);

        // R5/R6: random set/clear against model
        wr(8'h24, 32'hFFFF_FFFF);
        st = '0;
        imask = 5'($urandom);
        wr(8'h18, irq_w(imask));
        for (int it = 0; it < 20; it++) begin
            logic [31:0] w;
            w = $urandom;
            if ($urandom_range(1, 0) == 1) begin
                wr(8'h20, w); st = st | irq_v(w);
            end else begin
                wr(8'h24, w); st = st & ~irq_v(w);
            end
            rd(8'h1C, d); chk("R5 status model", d, irq_w(st));
            chk("R6 irq gating", {27'd0, tmr_irq}, {27'd0, st & imask});
        end
        rd(8'h20, d); chk("R5 set reads zero", d, 0);
        rd(8'h24, d); chk("R5 clear reads zero", d, 0);
        wr(8'h18, 32'h0000_F800);
        chk("R6 irq after mask write", {27'd0, tmr_irq}, {27'd0, st});

        // R5: match rise beats a clear in the same cycle
        wr(8'h80, {5'b00110, 27'd0});
        wr(8'hC0, 32'h0);
        wr(8'h84, {5'b11001, 27'd0});
        wr(8'hC4, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h20, irq_w(5'b00011));
        wr(8'h00, {5'b00110, 27'd0} - 32'd2);
        step(2);
        wr(8'h24, irq_w(5'b00011));
        rd(8'h1C, d); chk("R5 event wins over clear", d & irq_w(5'b00011), irq_w(5'b00001));

        finish_run();
    end

endmodule